// File: doc/BRIEF.md
# Coherence Reply Splitter

This block sits on the sending side of a tile's network interface, between the cache controller and two on-chip networks with different wire properties. It accepts one coherence message at a time: a class code, a transaction tag, a destination tile number, the byte offset of the word the processor asked for, and a full 64-byte cache line. Messages that need a fast answer leave on a narrow, low-latency channel. Bulky, non-urgent messages leave on a wide, low-energy channel.

A reply that carries data is split in two. A short partial reply holds only the aligned subblock around the requested word, so the processor can restart early. An ordinary reply follows with the whole line to fill the cache. Control messages without data go to the fast channel untouched. Write-backs and other non-critical data go whole to the wide channel. Each channel has its own one-entry output register and valid/ready handshake, so a stall on one channel does not hold up the other. A new message is taken only when both registers are free, or are being emptied in that same cycle.

Top module: `reply_splitter`

## Requirements
- R1: An accepted message of class 01 (data reply) makes both `nl_valid` and `we_valid` high in the cycle after acceptance.
- R2: For a data reply, the narrow message has type 01 (partial). `nl_base` is `in_off` rounded down to a multiple of SUB_BYTES. `nl_data` holds line bytes `nl_base` to `nl_base+SUB_BYTES-1`, with byte i of the line at `in_line[8i+7:8i]` and the lowest byte in the lowest bits.
- R3: For a data reply, the wide message has type 10 (ordinary). It carries the whole line unchanged in `we_data`, with `we_word` equal to `in_off`.
- R4: The narrow channel only ever presents types 00 (control) and 01 (partial). The wide channel only ever presents types 10 (ordinary) and 11 (write-back data).
- R5: SUB_BYTES may be set to 4 or to 16 (any power of two below the line size), and extraction follows R2 for each setting.
- R6: Both halves of a split reply carry the input's tag and destination.
- R7: A class 00 (control) message goes only to the narrow channel as type 00. It carries `nl_data` equal to the low SUB_BYTES*8 bits of `in_line` and `nl_base` equal to `in_off` unchanged. The wide channel stays idle.
- R8: Class 10 (write-back) and class 11 (other non-critical data) go only to the wide channel as type 11. They carry the whole line and `in_off` in `we_word`. The narrow channel stays idle.
- R9: A channel whose ready is low keeps its valid high and its fields stable. The other channel still hands off its message.
- R10: `in_ready` is high only when each channel register is empty or is handed off in that same cycle.
- R11: While reset is asserted and after it is released, both valids are low and `in_ready` is high until a message arrives. Reset release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input message present |
| in_ready | output | 1 | Input message taken this cycle when valid |
| in_cls | input | 2 | Class: 00 control, 01 data reply, 10 write-back, 11 other non-critical data |
| in_tag | input | TAG_W | Transaction tag |
| in_dest | input | DEST_W | Destination tile |
| in_off | input | log2(LINE_BYTES) | Byte offset of the requested word |
| in_line | input | LINE_BYTES*8 | Cache line or control payload |
| nl_valid | output | 1 | Low-latency message valid |
| nl_ready | input | 1 | Low-latency channel accepts |
| nl_type | output | 2 | Message type (00 control, 01 partial) |
| nl_tag | output | TAG_W | Tag |
| nl_dest | output | DEST_W | Destination |
| nl_base | output | log2(LINE_BYTES) | Subblock base offset, or control offset |
| nl_data | output | SUB_BYTES*8 | Subblock or control payload |
| we_valid | output | 1 | Low-energy message valid |
| we_ready | input | 1 | Low-energy channel accepts |
| we_type | output | 2 | Message type (10 ordinary, 11 write-back data) |
| we_tag | output | TAG_W | Tag |
| we_dest | output | DEST_W | Destination |
| we_word | output | log2(LINE_BYTES) | Requested word offset |
| we_data | output | LINE_BYTES*8 | Full cache line |

## Verification
Two things can happen in the same cycle. One channel can hand off its half of a split reply while the other half sits stalled. The stalled half can drain on the very edge that accepts the next input. The bench holds `we_ready` low with a new reply waiting, so the partial reply leaves while the ordinary reply and the input stay frozen. It then raises `we_ready` and expects `in_ready` to rise in that same cycle and the new pair to appear one edge later. The mirror case, with the narrow channel stalled, is also run. Both subblock sizes are swept over every class and every byte offset, with expected bytes computed from the line pattern.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam logic [1:0] MT_CTRL = 2'b00;
  localparam logic [1:0] MT_PART = 2'b01;
  localparam logic [1:0] MT_ORD  = 2'b10;
  localparam logic [1:0] MT_WB   = 2'b11;

  localparam logic [1:0] CL_CTRL   = 2'b00;
  localparam logic [1:0] CL_DREPLY = 2'b01;
  localparam logic [1:0] CL_WB     = 2'b10;
  localparam logic [1:0] CL_NCDATA = 2'b11;
endpackage

// File: rtl/rsp_rst_sync.sv
module rsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rsp_classify.sv
module rsp_classify
  import rsp_pkg::*;
(
  input  logic [1:0] cls,
  output logic       go_narrow,
  output logic       go_wide,
  output logic [1:0] n_type,
  output logic [1:0] w_type
);
  always_comb begin
    go_narrow = 1'b0;
    go_wide   = 1'b0;
    n_type    = MT_CTRL;
    w_type    = MT_WB;
    unique case (cls)
      CL_CTRL: go_narrow = 1'b1;
      CL_DREPLY: begin
        go_narrow = 1'b1;
        go_wide   = 1'b1;
        n_type    = MT_PART;
        w_type    = MT_ORD;
      end
      CL_WB, CL_NCDATA: go_wide = 1'b1;
      default: go_wide = 1'b1;
    endcase
  end
endmodule

// File: rtl/rsp_subblk.sv
module rsp_subblk #(
  parameter int LINE_BYTES = 64,
  parameter int SUB_BYTES  = 16
) (
  input  logic [LINE_BYTES*8-1:0]         line,
  input  logic [$clog2(LINE_BYTES)-1:0]   off,
  output logic [SUB_BYTES*8-1:0]          sub_data,
  output logic [$clog2(LINE_BYTES)-1:0]   sub_base
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SB_LG = $clog2(SUB_BYTES);
  localparam int NSUB  = LINE_BYTES / SUB_BYTES;
  localparam int SEL_W = (OFF_W - SB_LG) < 1 ? 1 : (OFF_W - SB_LG);
  localparam int SUB_W = SUB_BYTES * 8;

  logic [SUB_W-1:0] slices [NSUB];
  logic [SEL_W-1:0] sel;

  for (genvar g = 0; g < NSUB; g++) begin : g_slice
    assign slices[g] = line[g*SUB_W +: SUB_W];
  end

  assign sel      = SEL_W'(off >> SB_LG);
  assign sub_data = slices[sel];
  assign sub_base = off & ~OFF_W'(SUB_BYTES - 1);
endmodule

// File: rtl/rsp_slot.sv
module rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] pld_i,
  input  logic         rdy_i,
  output logic         vld_o,
  output logic [W-1:0] pld_o,
  output logic         free_o
);
  logic         vld_q, vld_d;
  logic [W-1:0] pld_q;

  always_comb begin
    vld_d = vld_q;
    if (load)       vld_d = 1'b1;
    else if (rdy_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) pld_q <= pld_i;
  end

  assign vld_o  = vld_q;
  assign pld_o  = pld_q;
  assign free_o = !vld_q || rdy_i;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rdy_i) |=> (vld_q && $stable(pld_q)));
endmodule

// File: rtl/reply_splitter.sv
module reply_splitter
  import rsp_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int SUB_BYTES  = 16,
  parameter int TAG_W      = 8,
  parameter int DEST_W     = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [1:0]                    in_cls,
  input  logic [TAG_W-1:0]              in_tag,
  input  logic [DEST_W-1:0]             in_dest,
  input  logic [$clog2(LINE_BYTES)-1:0] in_off,
  input  logic [LINE_BYTES*8-1:0]       in_line,
  output logic                          nl_valid,
  input  logic                          nl_ready,
  output logic [1:0]                    nl_type,
  output logic [TAG_W-1:0]              nl_tag,
  output logic [DEST_W-1:0]             nl_dest,
  output logic [$clog2(LINE_BYTES)-1:0] nl_base,
  output logic [SUB_BYTES*8-1:0]        nl_data,
  output logic                          we_valid,
  input  logic                          we_ready,
  output logic [1:0]                    we_type,
  output logic [TAG_W-1:0]              we_tag,
  output logic [DEST_W-1:0]             we_dest,
  output logic [$clog2(LINE_BYTES)-1:0] we_word,
  output logic [LINE_BYTES*8-1:0]       we_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SUB_W  = SUB_BYTES * 8;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int NP_W   = 2 + TAG_W + DEST_W + OFF_W + SUB_W;
  localparam int WP_W   = 2 + TAG_W + DEST_W + OFF_W + LINE_W;

  logic             rst_sync_n;
  logic             go_narrow, go_wide;
  logic [1:0]       n_type, w_type;
  logic [SUB_W-1:0] sub_data, n_data;
  logic [OFF_W-1:0] sub_base, n_off;
  logic             n_free, w_free, accept, n_load, w_load;
  logic [NP_W-1:0]  n_pld_in, n_pld_q;
  logic [WP_W-1:0]  w_pld_in, w_pld_q;

  rsp_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rsp_classify u_cls (
    .cls(in_cls), .go_narrow(go_narrow), .go_wide(go_wide),
    .n_type(n_type), .w_type(w_type)
  );

  rsp_subblk #(.LINE_BYTES(LINE_BYTES), .SUB_BYTES(SUB_BYTES)) u_sub (
    .line(in_line), .off(in_off), .sub_data(sub_data), .sub_base(sub_base)
  );

  always_comb begin
    if (in_cls == CL_CTRL) begin
      n_data = in_line[SUB_W-1:0];
      n_off  = in_off;
    end else begin
      n_data = sub_data;
      n_off  = sub_base;
    end
  end

  assign in_ready = n_free && w_free;
  assign accept   = in_valid && in_ready;
  assign n_load   = accept && go_narrow;
  assign w_load   = accept && go_wide;
  assign n_pld_in = {n_type, in_tag, in_dest, n_off, n_data};
  assign w_pld_in = {w_type, in_tag, in_dest, in_off, in_line};

  rsp_slot #(.W(NP_W)) u_nslot (
    .clk(clk), .rst_n(rst_sync_n), .load(n_load), .pld_i(n_pld_in),
    .rdy_i(nl_ready), .vld_o(nl_valid), .pld_o(n_pld_q), .free_o(n_free)
  );

  rsp_slot #(.W(WP_W)) u_wslot (
    .clk(clk), .rst_n(rst_sync_n), .load(w_load), .pld_i(w_pld_in),
    .rdy_i(we_ready), .vld_o(we_valid), .pld_o(w_pld_q), .free_o(w_free)
  );

  assign {nl_type, nl_tag, nl_dest, nl_base, nl_data} = n_pld_q;
  assign {we_type, we_tag, we_dest, we_word, we_data} = w_pld_q;

  // R1
  split_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && in_cls == CL_DREPLY) |=>
      (nl_valid && we_valid && nl_type == MT_PART && we_type == MT_ORD));

  // R6
  pair_tag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && in_cls == CL_DREPLY) |=>
      (nl_tag == we_tag && nl_dest == we_dest));

  // R4
  narrow_kind_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nl_valid |-> (nl_type == MT_CTRL || nl_type == MT_PART));

  // R4
  wide_kind_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    we_valid |-> (we_type == MT_ORD || we_type == MT_WB));

  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nl_valid && nl_type == MT_PART) |-> ((nl_base & OFF_W'(SUB_BYTES - 1)) == '0));

  // R7
  ctrl_no_wide_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && in_cls == CL_CTRL) |=> (!we_valid && nl_type == MT_CTRL));
endmodule

// File: tb/test_reply_splitter.sv
module test_reply_splitter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, in_valid, nl_ready, we_ready;
  logic [1:0]   in_cls;
  logic [7:0]   in_tag;
  logic [5:0]   in_dest, in_off;
  logic [511:0] in_line;

  logic a_in_ready, a_nl_valid, a_we_valid;
  logic [1:0] a_nl_type, a_we_type;
  logic [7:0] a_nl_tag, a_we_tag;
  logic [5:0] a_nl_dest, a_we_dest, a_nl_base, a_we_word;
  logic [127:0] a_nl_data;
  logic [511:0] a_we_data;

  logic b_in_ready, b_nl_valid, b_we_valid;
  logic [1:0] b_nl_type, b_we_type;
  logic [7:0] b_nl_tag, b_we_tag;
  logic [5:0] b_nl_dest, b_we_dest, b_nl_base, b_we_word;
  logic [31:0] b_nl_data;
  logic [511:0] b_we_data;

  int checks = 0;
  int errors = 0;

  reply_splitter #(.SUB_BYTES(16)) i_reply_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_in_ready),
    .in_cls(in_cls), .in_tag(in_tag), .in_dest(in_dest), .in_off(in_off),
    .in_line(in_line), .nl_valid(a_nl_valid), .nl_ready(nl_ready),
    .nl_type(a_nl_type), .nl_tag(a_nl_tag), .nl_dest(a_nl_dest),
    .nl_base(a_nl_base), .nl_data(a_nl_data), .we_valid(a_we_valid),
    .we_ready(we_ready), .we_type(a_we_type), .we_tag(a_we_tag),
    .we_dest(a_we_dest), .we_word(a_we_word), .we_data(a_we_data)
  );

  reply_splitter #(.SUB_BYTES(4)) i_reply_splitter_s4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_in_ready),
    .in_cls(in_cls), .in_tag(in_tag), .in_dest(in_dest), .in_off(in_off),
    .in_line(in_line), .nl_valid(b_nl_valid), .nl_ready(nl_ready),
    .nl_type(b_nl_type), .nl_tag(b_nl_tag), .nl_dest(b_nl_dest),
    .nl_base(b_nl_base), .nl_data(b_nl_data), .we_valid(b_we_valid),
    .we_ready(we_ready), .we_type(b_we_type), .we_tag(b_we_tag),
    .we_dest(b_we_dest), .we_word(b_we_word), .we_data(b_we_data)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] make_line(input int seed);
    logic [511:0] ln;
    for (int i = 0; i < 64; i++) ln[i*8 +: 8] = 8'((i * 37 + seed * 11 + 1) & 255);
    return ln;
  endfunction

  function automatic logic [127:0] exp_sub(input logic [511:0] ln, input int off, input int sb);
    int base;
    logic [127:0] r;
    base = (off / sb) * sb;
    r = '0;
    for (int i = 0; i < sb; i++) r[i*8 +: 8] = ln[(base + i)*8 +: 8];
    return r;
  endfunction

  task automatic drive(input int cls, input int off, input int seed, input int tag, input int dest);
    in_cls  = 2'(cls);
    in_off  = 6'(off);
    in_tag  = 8'(tag);
    in_dest = 6'(dest);
    in_line = make_line(seed);
    in_valid = 1'b1;
  endtask

  // outputs expected one cycle after acceptance of (cls, off, seed, tag, dest)
  task automatic check_out(input int cls, input int off, input int seed, input int tag, input int dest);
    logic [511:0] ln;
    bit nv, wv;
    ln = make_line(seed);
    nv = (cls <= 1);
    wv = (cls != 0);
    chk("R1 R7 R8 nl_valid", 512'(a_nl_valid), 512'(nv));
    chk("R1 R7 R8 we_valid", 512'(a_we_valid), 512'(wv));
    chk("R5 s4 nl_valid", 512'(b_nl_valid), 512'(nv));
    chk("R5 s4 we_valid", 512'(b_we_valid), 512'(wv));
    if (cls == 0) begin
      chk("R7 ctrl type", 512'(a_nl_type), 512'(0));
      chk("R7 ctrl data", 512'(a_nl_data), 512'(ln[127:0]));
      chk("R7 ctrl base", 512'(a_nl_base), 512'(off));
      chk("R7 s4 ctrl data", 512'(b_nl_data), 512'(ln[31:0]));
      chk("R7 s4 ctrl base", 512'(b_nl_base), 512'(off));
    end else if (cls == 1) begin
      chk("R2 part type", 512'(a_nl_type), 512'(1));
      chk("R2 sub16 data", 512'(a_nl_data), 512'(exp_sub(ln, off, 16)));
      chk("R2 sub16 base", 512'(a_nl_base), 512'((off / 16) * 16));
      chk("R5 sub4 data", 512'(b_nl_data), 512'(exp_sub(ln, off, 4)));
      chk("R5 sub4 base", 512'(b_nl_base), 512'((off / 4) * 4));
      chk("R6 nl tag", 512'(a_nl_tag), 512'(tag));
      chk("R6 nl dest", 512'(a_nl_dest), 512'(dest));
      chk("R6 we tag", 512'(a_we_tag), 512'(tag));
      chk("R6 we dest", 512'(a_we_dest), 512'(dest));
      chk("R3 ord type", 512'(a_we_type), 512'(2));
    end else begin
      chk("R8 wb type", 512'(a_we_type), 512'(3));
      chk("R8 s4 wb type", 512'(b_we_type), 512'(3));
    end
    if (cls != 0) begin
      chk("R3 R8 we_data", a_we_data, ln);
      chk("R3 R8 we_word", 512'(a_we_word), 512'(off));
      chk("R3 R8 s4 we_data", b_we_data, ln);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; nl_ready = 1'b1; we_ready = 1'b1;
    in_cls = '0; in_tag = '0; in_dest = '0; in_off = '0; in_line = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset nl_valid", 512'(a_nl_valid), 512'(0));
    chk("R11 reset we_valid", 512'(a_we_valid), 512'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 idle nl_valid", 512'(a_nl_valid | b_nl_valid), 512'(0));
    chk("R11 idle we_valid", 512'(a_we_valid | b_we_valid), 512'(0));
    chk("R11 idle in_ready", 512'(a_in_ready & b_in_ready), 512'(1));

    // sweep every class and every byte offset
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 64; o++) begin
        drive(c, o, c * 64 + o, (o * 5 + c) & 255, (o + c) & 63);
        chk("R10 ready before accept", 512'(a_in_ready), 512'(1));
        @(negedge clk);
        in_valid = 1'b0;
        check_out(c, o, c * 64 + o, (o * 5 + c) & 255, (o + c) & 63);
      end
    end
    @(negedge clk);

    // wide channel stalled: partial leaves, ordinary and input held
    we_ready = 1'b0;
    drive(1, 20, 5, 8'h11, 3);
    @(negedge clk);
    check_out(1, 20, 5, 8'h11, 3);
    drive(1, 45, 9, 8'h22, 7);
    chk("R10 busy wide in_ready", 512'(a_in_ready), 512'(0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 narrow proceeds", 512'(a_nl_valid), 512'(0));
      chk("R9 wide held valid", 512'(a_we_valid), 512'(1));
      chk("R9 wide held data", a_we_data, make_line(5));
      chk("R9 wide held tag", 512'(a_we_tag), 512'(8'h11));
      chk("R10 blocked in_ready", 512'(a_in_ready | b_in_ready), 512'(0));
    end
    we_ready = 1'b1;
    #1;
    chk("R10 same-cycle drain in_ready", 512'(a_in_ready), 512'(1));
    @(negedge clk);
    in_valid = 1'b0;
    check_out(1, 45, 9, 8'h22, 7);
    @(negedge clk);

    // narrow channel stalled: ordinary leaves, partial held
    nl_ready = 1'b0;
    drive(1, 63, 12, 8'h33, 9);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(1, 63, 12, 8'h33, 9);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 wide proceeds", 512'(a_we_valid), 512'(0));
      chk("R9 narrow held valid", 512'(a_nl_valid), 512'(1));
      chk("R9 narrow held data", 512'(a_nl_data), 512'(exp_sub(make_line(12), 63, 16)));
      chk("R9 s4 narrow held data", 512'(b_nl_data), 512'(exp_sub(make_line(12), 63, 4)));
      chk("R10 blocked by narrow", 512'(a_in_ready), 512'(0));
    end
    nl_ready = 1'b1;
    @(negedge clk);
    chk("R9 narrow drained", 512'(a_nl_valid), 512'(0));
    chk("R10 ready after drain", 512'(a_in_ready), 512'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule